// File: doc/BRIEF.md
# Interrupt Vector Table and Pending Controller

This block holds a table of message-signalled interrupt vectors and a bitmap of pending vectors. It decides, for each interrupt request, whether the request leaves as an outbound message or is held as a pending bit. Each table entry carries a 64-bit destination address, a 32-bit payload and a per-vector mask. A function-wide enable and mask, written through a configuration strobe, gate every vector at once.

Clearing a mask, for one vector or for the whole function, replays any vector that was held pending. A per-vector use count lets the owning device declare which vectors it actually drives. Requests for vectors with a zero count, or with an index past the table, are dropped. Software reaches the table and the pending bitmap through a 32-bit-dword register port that also accepts 8-byte accesses.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Vector v occupies dwords 4v..4v+3 of the table region, holding address low, address high, payload and control, in that order. Control bit 0 is the vector mask. All four read back what was last written, and the upper 31 control bits read 0.
- R2: Vector v's pending flag is bit v mod 32 of dword v div 32 of the pending region, which is equivalent to bit v mod 8 of byte v div 8. The region spans ceil(N/64)*2 dwords. Bits for vectors at or above N read 0. Writes to the pending region change nothing.
- R3: A vector is masked when its own mask bit is set or the function is masked. The function is masked when the enable bit is clear or the function-mask bit is set.
- R4: A request for an unmasked, in-use vector produces one message carrying that entry's address and payload. A request for a masked, in-use vector sets its pending bit and produces no message.
- R5: A request whose index is N or more, or whose vector has a use count of zero, produces no message and sets no pending bit.
- R6: When a vector goes from masked to unmasked with its pending bit set, the pending bit clears and the vector's message is sent. This holds whether the change comes from a table write or from a configuration write.
- R7: Vectors released by one unmask event leave in ascending index order, one per accepted handshake. While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold.
- R8: An 8-byte write is applied as two dword writes over two cycles, the lower address first, and mm_ready is low in the second cycle. The unmask check runs after each dword. An 8-byte read returns the dword at the given address in bits 31:0 and the next dword in bits 63:32, one cycle after acceptance.
- R9: A use increment raises a vector's count and a decrement lowers it. A decrement at zero has no effect. A decrement that reaches zero clears the vector's pending bit.
- R10: cfg_rdata bits 10:0 read N-1, bit 15 reads the enable bit, bit 14 reads the function-mask bit, and the other bits read 0.
- R11: Reset clears the enable and function-mask bits, all pending bits, all use counts and the whole table, then sets every vector's mask bit. msg_valid is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_valid | input | 1 | Register access request |
| mm_ready | output | 1 | Access accepted when high together with mm_valid |
| mm_write | input | 1 | 1 = write, 0 = read |
| mm_pba | input | 1 | 1 = pending region, 0 = table region |
| mm_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mm_addr | input | AW | Dword address within the region |
| mm_wdata | input | 64 | Write data; bits 63:32 are used only for wide writes |
| mm_rvalid | output | 1 | Read data valid |
| mm_rdata | output | 64 | Read data: addressed dword in 31:0, next dword in 63:32 |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_enable | input | 1 | New enable bit |
| cfg_fmask | input | 1 | New function-mask bit |
| cfg_rdata | output | 16 | Control word: enable, function mask, table size minus one |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VIW | Requested vector index |
| use_inc | input | 1 | Increment use count of use_vec |
| use_dec | input | 1 | Decrement use count of use_vec |
| use_vec | input | VIW | Vector for the use-count operation |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |

## Verification
A replay caused by an unmask can collide with a blocked output channel. The bench provokes this by holding msg_ready low and then lifting the function mask while four vectors are pending. It checks that the first message holds its values for several cycles and that all four messages then leave in ascending order. A second collision puts a payload write and a mask clear in the two halves of one 8-byte write. That the replayed message carries the new payload shows the lower dword landed before the unmask check.

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter int NVEC = 8,
  parameter int AW   = 10,
  parameter int VIW  = 11,
  parameter int CW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mm_valid,
  output logic           mm_ready,
  input  logic           mm_write,
  input  logic           mm_pba,
  input  logic           mm_wide,
  input  logic [AW-1:0]  mm_addr,
  input  logic [63:0]    mm_wdata,
  output logic           mm_rvalid,
  output logic [63:0]    mm_rdata,
  input  logic           cfg_we,
  input  logic           cfg_enable,
  input  logic           cfg_fmask,
  output logic [15:0]    cfg_rdata,
  input  logic           irq_valid,
  input  logic [VIW-1:0] irq_vec,
  input  logic           use_inc,
  input  logic           use_dec,
  input  logic [VIW-1:0] use_vec,
  output logic           msg_valid,
  input  logic           msg_ready,
  output logic [63:0]    msg_addr,
  output logic [31:0]    msg_data
);
  localparam int PDW   = ((NVEC + 63) / 64) * 2;
  localparam int PBITS = PDW * 32;
  localparam int SW    = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic            en_q, fm_q;
  logic [31:0]     t_lo  [NVEC];
  logic [31:0]     t_hi  [NVEC];
  logic [31:0]     t_dat [NVEC];
  logic [CW-1:0]   cnt   [NVEC];
  logic [NVEC-1:0] t_msk, pba, req, msk_q;
  logic            ph2, ph2_pba;
  logic [AW-1:0]   ph2_idx;
  logic [31:0]     ph2_dat;

  assign mm_ready  = !ph2;
  assign cfg_rdata = {en_q, fm_q, 3'b000, 11'(NVEC - 1)};

  wire          acc    = mm_valid && mm_ready;
  wire          wr_en  = ph2 || (acc && mm_write);
  wire          wr_pba = ph2 ? ph2_pba : mm_pba;
  wire [AW-1:0] wr_idx = ph2 ? ph2_idx : mm_addr;
  wire [31:0]   wr_dat = ph2 ? ph2_dat : mm_wdata[31:0];

  wire            fmask   = !en_q || fm_q;
  wire [NVEC-1:0] msk_now = t_msk | {NVEC{fmask}};
  wire [NVEC-1:0] unm     = msk_q & ~msk_now & pba;

  logic [NVEC-1:0] hit, zclr, pick;
  logic [SW-1:0]   sel;

  always_comb begin
    hit  = '0;
    zclr = '0;
    pick = '0;
    sel  = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (irq_valid && int'(irq_vec) == v && cnt[v] != '0) hit[v] = 1'b1;
      if (use_dec && !use_inc && int'(use_vec) == v && cnt[v] == CW'(1)) zclr[v] = 1'b1;
    end
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (req[v]) begin
        pick = '0;
        pick[v] = 1'b1;
        sel = SW'(v);
      end
    end
  end

  wire load = (|req) && (!msg_valid || msg_ready);

  function automatic logic [31:0] rd_dw(input logic is_pba, input logic [AW-1:0] idx);
    logic [PBITS-1:0] pext;
    pext  = PBITS'(pba);
    rd_dw = '0;
    if (is_pba) begin
      if (int'(idx) < PDW) rd_dw = pext[int'(idx) * 32 +: 32];
    end else if (int'(idx[AW-1:2]) < NVEC) begin
      case (idx[1:0])
        2'd0:    rd_dw = t_lo[int'(idx[AW-1:2])];
        2'd1:    rd_dw = t_hi[int'(idx[AW-1:2])];
        2'd2:    rd_dw = t_dat[int'(idx[AW-1:2])];
        default: rd_dw = {31'd0, t_msk[int'(idx[AW-1:2])]};
      endcase
    end
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_rvalid <= 1'b0;
      mm_rdata  <= '0;
    end else begin
      mm_rvalid <= acc && !mm_write;
      if (acc && !mm_write)
        mm_rdata <= {rd_dw(mm_pba, mm_addr + AW'(1)), rd_dw(mm_pba, mm_addr)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      fm_q      <= 1'b0;
      t_msk     <= '1;
      msk_q     <= '1;
      pba       <= '0;
      req       <= '0;
      ph2       <= 1'b0;
      ph2_pba   <= 1'b0;
      ph2_idx   <= '0;
      ph2_dat   <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      for (int v = 0; v < NVEC; v++) begin
        t_lo[v]  <= '0;
        t_hi[v]  <= '0;
        t_dat[v] <= '0;
        cnt[v]   <= '0;
      end
    end else begin
      msk_q <= msk_now;
      pba   <= ((pba & ~unm) | (hit & msk_now)) & ~zclr;
      req   <= (req & ~(load ? pick : '0)) | unm | (hit & ~msk_now);

      if (cfg_we) begin
        en_q <= cfg_enable;
        fm_q <= cfg_fmask;
      end

      ph2 <= acc && mm_write && mm_wide;
      if (acc) begin
        ph2_pba <= mm_pba;
        ph2_idx <= mm_addr + AW'(1);
        ph2_dat <= mm_wdata[63:32];
      end

      for (int v = 0; v < NVEC; v++) begin
        if (wr_en && !wr_pba && int'(wr_idx[AW-1:2]) == v) begin
          case (wr_idx[1:0])
            2'd0:    t_lo[v]  <= wr_dat;
            2'd1:    t_hi[v]  <= wr_dat;
            2'd2:    t_dat[v] <= wr_dat;
            default: t_msk[v] <= wr_dat[0];
          endcase
        end
        if (int'(use_vec) == v) begin
          if (use_inc && !use_dec && cnt[v] != '1)
            cnt[v] <= cnt[v] + CW'(1);
          else if (use_dec && !use_inc && cnt[v] != '0)
            cnt[v] <= cnt[v] - CW'(1);
        end
      end

      if (load) begin
        msg_valid <= 1'b1;
        msg_addr  <= {t_hi[sel], t_lo[sel]};
        msg_data  <= t_dat[sel];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
  parameter int NVEC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mm_valid,
  input logic            mm_ready,
  input logic            mm_write,
  input logic            mm_wide,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic            en_q,
  input logic [NVEC-1:0] pba,
  input logic [NVEC-1:0] msk_q
);
  assert_msg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  assert_wide_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mm_valid && mm_ready && mm_write && mm_wide |=> !mm_ready);

  assert_split_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mm_ready |=> mm_ready);

  assert_pend_only_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pba & ~msk_q) == '0);

  assert_disable_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> &msk_q);
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NVEC(NVEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .mm_valid(mm_valid), .mm_ready(mm_ready),
  .mm_write(mm_write), .mm_wide(mm_wide), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
  .en_q(en_q), .pba(pba), .msk_q(msk_q)
);

// File: tb/msix_vec_ctrl_tb_top.sv
module msix_vec_ctrl_tb_top;
  localparam int N   = 40;
  localparam int AW  = 10;
  localparam int VIW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mm_valid = 0, mm_write = 0, mm_pba = 0, mm_wide = 0;
  logic [AW-1:0] mm_addr = '0;
  logic [63:0] mm_wdata = '0;
  logic mm_ready, mm_rvalid;
  logic [63:0] mm_rdata;
  logic cfg_we = 0, cfg_enable = 0, cfg_fmask = 0;
  logic [15:0] cfg_rdata;
  logic irq_valid = 0;
  logic [VIW-1:0] irq_vec = '0;
  logic use_inc = 0, use_dec = 0;
  logic [VIW-1:0] use_vec = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #2.5 clk = ~clk;

  msix_vec_ctrl #(.NVEC(N), .AW(AW), .VIW(VIW), .CW(4)) dut_i (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] bm_lo [N];
  logic [31:0] bm_hi [N];
  logic [31:0] bm_dat [N];
  logic [95:0] got [$];

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready) got.push_back({msg_addr, msg_data});

  function automatic logic [95:0] em(input int v);
    return {bm_hi[v], bm_lo[v], bm_dat[v]};
  endfunction

  task automatic check(input string rq, input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic mm_wr(input logic pb, input int dwa, input logic wide, input logic [63:0] d);
    while (!mm_ready) tick();
    mm_valid = 1; mm_write = 1; mm_pba = pb; mm_wide = wide;
    mm_addr = AW'(dwa); mm_wdata = d;
    tick();
    mm_valid = 0; mm_write = 0; mm_wide = 0;
    tick();
  endtask

  task automatic mm_rd(input logic pb, input int dwa, output logic [63:0] d);
    while (!mm_ready) tick();
    mm_valid = 1; mm_write = 0; mm_pba = pb; mm_addr = AW'(dwa);
    tick();
    mm_valid = 0;
    d = mm_rdata;
  endtask

  task automatic cfg(input logic en, input logic fm);
    cfg_we = 1; cfg_enable = en; cfg_fmask = fm;
    tick();
    cfg_we = 0;
  endtask

  task automatic irq(input int v);
    irq_valid = 1; irq_vec = VIW'(v);
    tick();
    irq_valid = 0;
  endtask

  task automatic use_op(input int v, input logic inc);
    use_vec = VIW'(v); use_inc = inc; use_dec = !inc;
    tick();
    use_inc = 0; use_dec = 0;
  endtask

  task automatic wait_msgs(input int n);
    for (int i = 0; i < 60 && got.size() < n; i++) tick();
  endtask

  task automatic settle();
    repeat (6) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [63:0] rd;
    logic [95:0] m;
    void'($urandom(32'd4242));
    for (int v = 0; v < N; v++) begin bm_lo[v] = 0; bm_hi[v] = 0; bm_dat[v] = 0; end
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R10 R11: reset state
    check("R10", 96'(cfg_rdata), 96'(16'd39));
    check("R11", 96'(msg_valid), 96'd0);
    mm_rd(0, 5 * 4 + 2, rd);
    check("R11", 96'(rd), {32'd0, 64'h0000_0001_0000_0000});
    mm_rd(1, 0, rd);
    check("R11", 96'(rd), 96'd0);

    // R1 R8: random table writes, narrow and wide, then readback
    for (int i = 0; i < 60; i++) begin
      int v, k;
      logic [63:0] d;
      v = int'($urandom_range(N - 1));
      k = int'($urandom_range(2));
      d = {$urandom(), $urandom()};
      if (k == 0) begin
        mm_wr(0, v * 4, 1, d); bm_lo[v] = d[31:0]; bm_hi[v] = d[63:32];
      end else if (k == 1) begin
        mm_wr(0, v * 4 + 1, 1, d); bm_hi[v] = d[31:0]; bm_dat[v] = d[63:32];
      end else begin
        mm_wr(0, v * 4 + 2, 0, d); bm_dat[v] = d[31:0];
      end
    end
    for (int v = 0; v < N; v++) begin
      mm_rd(0, v * 4, rd);
      check("R1", 96'(rd), 96'({bm_hi[v], bm_lo[v]}));
      mm_rd(0, v * 4 + 2, rd);
      check("R1", 96'(rd[31:0]), 96'(bm_dat[v]));
    end

    for (int v = 0; v < N; v++) if (v != 7) use_op(v, 1);
    use_op(15, 1);
    cfg(1, 0);
    check("R10", 96'(cfg_rdata), 96'(16'h8027));

    // R4: unmasked request emits message
    got.delete();
    mm_wr(0, 3 * 4 + 3, 0, 64'd0);
    irq(3);
    wait_msgs(1);
    check("R4", 96'(got.size()), 96'd1);
    if (got.size() > 0) check("R4", got[0], em(3));

    // R4 R2: masked requests set pending bits
    got.delete();
    irq(4);
    irq(35);
    settle();
    check("R4", 96'(got.size()), 96'd0);
    mm_rd(1, 0, rd);
    check("R2", 96'(rd), 96'({32'h0000_0008, 32'h0000_0010}));

    // R2: pending region writes ignored
    mm_wr(1, 0, 1, 64'h0);
    mm_rd(1, 0, rd);
    check("R2", 96'(rd[31:0]), 96'h10);

    // R5: unused vector and out-of-range index
    irq(7);
    irq(45);
    settle();
    mm_rd(1, 0, rd);
    check("R5", 96'(rd), 96'({32'h0000_0008, 32'h0000_0010}));
    check("R5", 96'(got.size()), 96'd0);

    // R6: per-vector unmask replays pending
    mm_wr(0, 4 * 4 + 3, 0, 64'd0);
    wait_msgs(1);
    check("R6", 96'(got.size()), 96'd1);
    if (got.size() > 0) check("R6", got[0], em(4));
    mm_rd(1, 0, rd);
    check("R6", 96'(rd[31:0]), 96'd0);

    // R3: function mask holds requests
    got.delete();
    cfg(1, 1);
    irq(3);
    irq(20);
    irq(10);
    mm_wr(0, 10 * 4 + 3, 0, 64'd0);
    mm_wr(0, 20 * 4 + 3, 0, 64'd0);
    mm_wr(0, 35 * 4 + 3, 0, 64'd0);
    settle();
    check("R3", 96'(got.size()), 96'd0);
    mm_rd(1, 0, rd);
    check("R3", 96'(rd), 96'({32'h0000_0008, 32'h0010_0408}));

    // R6 R7: function unmask under backpressure
    msg_ready = 0;
    cfg(1, 0);
    settle();
    m = {msg_addr, msg_data};
    check("R7", 96'(msg_valid), 96'd1);
    check("R7", m, em(3));
    repeat (3) tick();
    check("R7", {msg_addr, msg_data}, m);
    msg_ready = 1;
    wait_msgs(4);
    check("R7", 96'(got.size()), 96'd4);
    if (got.size() >= 4) begin
      check("R7", got[0], em(3));
      check("R7", got[1], em(10));
      check("R7", got[2], em(20));
      check("R7", got[3], em(35));
    end
    mm_rd(1, 0, rd);
    check("R6", 96'(rd), 96'd0);

    // R8: payload in lower half, mask clear in upper half
    got.delete();
    irq(12);
    bm_dat[12] = 32'h1234_5678;
    mm_wr(0, 12 * 4 + 2, 1, {32'd0, 32'h1234_5678});
    wait_msgs(1);
    check("R8", 96'(got.size()), 96'd1);
    if (got.size() > 0) check("R8", got[0], em(12));

    // R9 R5: use counts
    got.delete();
    irq(15);
    mm_rd(1, 0, rd);
    check("R9", 96'(rd[31:0]), 96'h8000);
    use_op(15, 0);
    mm_rd(1, 0, rd);
    check("R9", 96'(rd[31:0]), 96'h8000);
    use_op(15, 0);
    mm_rd(1, 0, rd);
    check("R9", 96'(rd[31:0]), 96'h0);
    irq(15);
    mm_rd(1, 0, rd);
    check("R5", 96'(rd[31:0]), 96'h0);
    use_op(15, 0);
    use_op(15, 1);
    irq(15);
    mm_rd(1, 0, rd);
    check("R9", 96'(rd[31:0]), 96'h8000);

    // R3: disable masks an unmasked vector
    cfg(0, 0);
    irq(4);
    settle();
    check("R3", 96'(got.size()), 96'd0);
    mm_rd(1, 0, rd);
    check("R3", 96'(rd[31:0]), 96'h8010);

    // R11: reset mid-run
    rst_n = 0;
    tick();
    rst_n = 1;
    tick();
    check("R11", 96'(cfg_rdata), 96'(16'd39));
    mm_rd(1, 0, rd);
    check("R11", 96'(rd), 96'd0);
    mm_rd(0, 4 * 4 + 2, rd);
    check("R11", 96'(rd), {32'd0, 64'h0000_0001_0000_0000});
    check("R11", 96'(msg_valid), 96'd0);

    finish_run();
  end
endmodule